// File: doc/BRIEF.md
# Host-to-Sound-Processor Command Mailbox

This block carries single bytes between a host processor and a sound coprocessor. The host has one sound register address. A host write to that address stores a command byte, and a host read from it returns the coprocessor's most recent reply. The coprocessor reads the command from one I/O port and posts its reply to another. The hardware gives no byte value a special meaning. Both sides run on the same clock, and each has its own bus with synchronous strobes.

Only the host-to-coprocessor direction signals the other side. When the coprocessor has its interrupt enable set, a new host write starts a fixed-length non-maskable interrupt pulse. The coprocessor sets and clears that enable by writing to two dedicated ports. A reply never interrupts the host. Both bus interfaces are plain strobe buses with no back-pressure: every strobe is accepted in the cycle it is sampled, and the read data registers hold their last value until the next decoded read.

Top module: `mbx_top`

## Requirements
- R1: After reset, both latches hold 0x00, the interrupt enable is off, `cop_nmi` is low, and both read data outputs are 0x00.
- R2: A host write with `host_addr` equal to `HOST_SND_ADDR` (default 0xC) stores `host_wdata` in the command latch. A coprocessor read of port 0x00 presents that byte on `cop_rdata` in the cycle after the read strobe. Every byte value 0x00 to 0xFF passes through unchanged.
- R3: When the enable is on, a host command write drives `cop_nmi` high, starting in the cycle after the write strobe and lasting exactly `NMI_LEN` cycles (default 8). When the enable is off, the same write leaves `cop_nmi` low.
- R4: A coprocessor write to port 0x08 turns the enable on, and a write to port 0x18 turns it off. The data byte on these writes is ignored.
- R5: A coprocessor write to port 0x0C stores `cop_wdata` in the reply latch. It never raises `cop_nmi` and leaves the command latch unchanged.
- R6: A host read of `HOST_SND_ADDR` presents the reply latch on `host_rdata` in the next cycle. The command latch is never visible to the host.
- R7: A write strobe held high over many cycles produces only one interrupt pulse. A new pulse needs the strobe to drop and rise again.
- R8: Each latch keeps its byte until it is overwritten, so repeated reads return the same value.
- R9: If a host command write and a coprocessor command read share a cycle, the read returns the previous command and the next read returns the new one.
- R10: Host accesses to any other address, and coprocessor accesses to any other port, change neither latch nor the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Reply byte returned to the host |
| cop_wr | input | 1 | Coprocessor I/O write strobe |
| cop_rd | input | 1 | Coprocessor I/O read strobe |
| cop_addr | input | 8 | Coprocessor I/O port number |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Command byte returned to the coprocessor |
| cop_nmi | output | 1 | Non-maskable interrupt pulse, active high |

## Verification
Each read result is due one cycle after its strobe, and the latches update at the same edge that samples the write strobe. The bench drives every strobe on a falling edge, holds it across exactly one rising edge, and samples the outputs at the following falling edge. The interrupt goes high at the first falling edge after the write. The bench counts its high samples over a window of `NMI_LEN` plus four cycles, which checks both the start of the pulse and its exact length. The same-cycle collision and the held-strobe cases are driven directly, and each result is sampled at the falling edge just after the edge in question.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t PORT_CMD_RD   = 8'h00;
  localparam byte_t PORT_REPLY_WR = 8'h0C;
  localparam byte_t PORT_NMI_ON   = 8'h08;
  localparam byte_t PORT_NMI_OFF  = 8'h18;
endpackage

// File: rtl/mbx_byte_latch.sv
module mbx_byte_latch
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t d,
  output byte_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R8
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter logic [HOST_AW-1:0] HOST_SND_ADDR = 'hC
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  byte_t              reply_q,
  output logic               cmd_we,
  output byte_t              host_rdata
);
  logic sel;
  assign sel    = (host_addr == HOST_SND_ADDR);
  assign cmd_we = host_wr & sel;

  always_ff @(posedge clk) begin
    if (!rst_n)              host_rdata <= '0;
    else if (host_rd && sel) host_rdata <= reply_q;
  end

  AST_HOST_GETS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel) |=> host_rdata == $past(reply_q)); // R6
endmodule

// File: rtl/mbx_cop_port.sv
module mbx_cop_port
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cop_wr,
  input  logic  cop_rd,
  input  byte_t cop_addr,
  input  byte_t cmd_q,
  output logic  reply_we,
  output logic  nmi_en,
  output byte_t cop_rdata
);
  logic en_set, en_clr, cmd_rd;
  assign reply_we = cop_wr && (cop_addr == PORT_REPLY_WR);
  assign en_set   = cop_wr && (cop_addr == PORT_NMI_ON);
  assign en_clr   = cop_wr && (cop_addr == PORT_NMI_OFF);
  assign cmd_rd   = cop_rd && (cop_addr == PORT_CMD_RD);

  always_ff @(posedge clk) begin
    if (!rst_n)      nmi_en <= 1'b0;
    else if (en_set) nmi_en <= 1'b1;
    else if (en_clr) nmi_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cop_rdata <= '0;
    else if (cmd_rd) cop_rdata <= cmd_q;
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> nmi_en); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !nmi_en); // R4
  AST_CMD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> cop_rdata == $past(cmd_q)); // R9
endmodule

// File: rtl/mbx_nmi_gen.sv
module mbx_nmi_gen #(
  parameter int NMI_LEN = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic nmi_en,
  output logic nmi
);
  localparam int CW = (NMI_LEN > 1) ? $clog2(NMI_LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(NMI_LEN - 1);

  logic          hit_q;
  logic          fire;
  logic [CW-1:0] left;

  assign fire = wr_hit && !hit_q && nmi_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      nmi   <= 1'b0;
      left  <= '0;
    end else begin
      hit_q <= wr_hit;
      if (fire) begin
        nmi  <= 1'b1;
        left <= LOAD;
      end else if (nmi) begin
        if (left == '0) nmi  <= 1'b0;
        else            left <= left - 1'b1;
      end
    end
  end

  // Separate width counter used only by the checks below.
  logic [CW:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)             run <= '0;
    else if (fire)          run <= (CW+1)'(1);
    else if (nmi)           run <= run + 1'b1;
    else                    run <= '0;
  end

  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(wr_hit && nmi_en)); // R3
  AST_NMI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> run <= (CW+1)'(NMI_LEN)); // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && hit_q && !nmi) |=> !nmi); // R7
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter logic [HOST_AW-1:0] HOST_SND_ADDR = 'hC,
  parameter int NMI_LEN = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               cop_wr,
  input  logic               cop_rd,
  input  logic [7:0]         cop_addr,
  input  logic [7:0]         cop_wdata,
  output logic [7:0]         cop_rdata,
  output logic               cop_nmi
);
  logic  cmd_we, reply_we, nmi_en;
  byte_t cmd_q, reply_q;

  mbx_host_port #(.HOST_AW(HOST_AW), .HOST_SND_ADDR(HOST_SND_ADDR)) host_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .reply_q(reply_q), .cmd_we(cmd_we),
    .host_rdata(host_rdata));

  mbx_cop_port cop_i (
    .clk(clk), .rst_n(rst_n), .cop_wr(cop_wr), .cop_rd(cop_rd),
    .cop_addr(cop_addr), .cmd_q(cmd_q), .reply_we(reply_we),
    .nmi_en(nmi_en), .cop_rdata(cop_rdata));

  mbx_byte_latch cmd_latch_i (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .d(host_wdata), .q(cmd_q));

  mbx_byte_latch reply_latch_i (
    .clk(clk), .rst_n(rst_n), .we(reply_we), .d(cop_wdata), .q(reply_q));

  mbx_nmi_gen #(.NMI_LEN(NMI_LEN)) nmi_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(cmd_we), .nmi_en(nmi_en), .nmi(cop_nmi));

  AST_REPLY_NO_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_we && !cmd_we && !cop_nmi) |=> !cop_nmi); // R5
  AST_REPLY_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_we && !cmd_we) |=> $stable(cmd_q)); // R5
endmodule

// File: tb/mbx_top_tb_top.sv
module mbx_top_tb_top;
  localparam int L = 8;
  localparam logic [3:0] SND = 4'hC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, cop_wr = 0, cop_rd = 0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, cop_addr = '0, cop_wdata = '0;
  logic [7:0] host_rdata, cop_rdata;
  logic cop_nmi;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mbx_top #(.HOST_AW(4), .HOST_SND_ADDR(SND), .NMI_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_wr(cop_wr), .cop_rd(cop_rd), .cop_addr(cop_addr),
    .cop_wdata(cop_wdata), .cop_rdata(cop_rdata), .cop_nmi(cop_nmi));

  // {command, enable (1=on), reply}
  localparam logic [23:0] VEC [8] = '{
    24'h01_01_81, 24'h00_01_FF, 24'hFF_00_00, 24'h03_01_83,
    24'hA5_00_5A, 24'h7E_01_FE, 24'h80_00_01, 24'h02_01_55};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = SND;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic cop_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cop_wr = 1; cop_addr = a; cop_wdata = d;
    @(negedge clk); cop_wr = 0;
  endtask

  task automatic cop_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cop_rd = 1; cop_addr = a;
    @(negedge clk); cop_rd = 0; d = cop_rdata;
  endtask

  // Called at the negedge right after the write edge.
  task automatic count_nmi(output int n, output bit first);
    n = 0; first = cop_nmi;
    for (int i = 0; i < L + 4; i++) begin
      if (cop_nmi) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    bit f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cop_nmi == 0, "R1 nmi", cop_nmi, 0);
    chk(host_rdata == 0 && cop_rdata == 0, "R1 rdata", host_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    host_read(r); chk(r == 8'h00, "R1 reply latch", r, 0);
    cop_read(8'h00, r); chk(r == 8'h00, "R1 cmd latch", r, 0);
    host_write(SND, 8'h11); count_nmi(n, f);
    chk(n == 0, "R1 enable off after reset", n, 0);

    // Table walk: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      cop_write(VEC[i][8] ? 8'h08 : 8'h18, 8'hEE);
      host_write(SND, VEC[i][23:16]); count_nmi(n, f);
      if (VEC[i][8]) begin
        chk(f == 1'b1, "R3 pulse start", f, 1);
        chk(n == L, "R3 pulse width", n, L);
      end else
        chk(n == 0, "R3/R4 gated off", n, 0);
      cop_read(8'h00, r); chk(r == VEC[i][23:16], "R2 command", r, VEC[i][23:16]);
      cop_write(8'h0C, VEC[i][7:0]); count_nmi(n, f);
      chk(n == 0, "R5 reply no nmi", n, 0);
      cop_read(8'h00, r); chk(r == VEC[i][23:16], "R5 cmd kept", r, VEC[i][23:16]);
      host_read(r); chk(r == VEC[i][7:0], "R6 reply", r, VEC[i][7:0]);
    end

    // R2 every byte value
    begin
      int bad = 0;
      for (int v = 0; v < 256; v++) begin
        host_write(SND, 8'(v)); cop_read(8'h00, r);
        if (r != 8'(v)) bad++;
      end
      chk(bad == 0, "R2 all bytes", bad, 0);
    end

    // R8 repeated reads
    host_write(SND, 8'h3C); cop_write(8'h0C, 8'hC3);
    cop_read(8'h00, r); cop_read(8'h00, r); chk(r == 8'h3C, "R8 cmd hold", r, 8'h3C);
    host_read(r); host_read(r); chk(r == 8'hC3, "R8 reply hold", r, 8'hC3);

    // R9 same-cycle write and read
    @(negedge clk); host_wr = 1; host_addr = SND; host_wdata = 8'h5A;
    cop_rd = 1; cop_addr = 8'h00;
    @(negedge clk); host_wr = 0; cop_rd = 0;
    chk(cop_rdata == 8'h3C, "R9 old value", cop_rdata, 8'h3C);
    cop_read(8'h00, r); chk(r == 8'h5A, "R9 new value", r, 8'h5A);

    // R7 held strobe
    cop_write(8'h08, 8'h00);
    @(negedge clk); host_wr = 1; host_addr = SND; host_wdata = 8'h42;
    n = 0;
    for (int i = 0; i < 3 * L; i++) begin
      @(negedge clk); if (cop_nmi) n++;
    end
    host_wr = 0;
    chk(n == L, "R7 single pulse", n, L);

    // R10 other addresses
    repeat (L + 2) @(negedge clk);
    host_write(4'h3, 8'h99); count_nmi(n, f);
    chk(n == 0, "R10 host other addr nmi", n, 0);
    cop_read(8'h00, r); chk(r == 8'h42, "R10 cmd unchanged", r, 8'h42);
    cop_write(8'h0D, 8'h77); host_read(r);
    chk(r == 8'hC3, "R10 reply unchanged", r, 8'hC3);
    cop_write(8'h19, 8'h00);
    host_write(SND, 8'h01); count_nmi(n, f);
    chk(n == L, "R10/R4 enable untouched by other port", n, L);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule